// File: doc/BRIEF.md
# Operand Effective Address Calculator

This block works out where an instruction operand lives for a processor with eight data registers and eight address registers. The decoder gives it a 3-bit mode, a 3-bit register number, an operand size and a start strobe. The block reads register contents through two combinational read ports. It pulls any extension words it needs from the instruction stream, one 16-bit word per valid/ready handshake. When it finishes it returns four things: the operand's 24-bit address (or marks the operand as a register or an immediate), any stepped address-register value that must be written back, the advanced program counter, and an error flag for encodings it cannot accept.

The caller performs the operand access, the register write and the program counter update itself. Register contents must stay stable from start until done.

Top module: `ea_calc_unit`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o` and `fetch_valid_o` are all 0.
- R2: Modes 0 and 1 are register operands. `kind_o` reads 1 for a data register and 2 for an address register, no extension word is fetched, and `done_o` rises in the cycle after start.
- R3: Modes 2, 3 and 4 use address register `reg_i` as the address. Mode 3 writes back the register plus the step. Mode 4 writes back the register minus the step and also uses that value as the address. The step is 1, 2 or 4 for size 0 (byte), 1 (word) or 2/3 (long), except that a byte step on register 7 is 2.
- R4: Mode 5 adds one sign-extended 16-bit extension word to the address register.
- R5: Mode 6 and mode 7/submode 3 read one index word, laid out as follows. Bit 15 selects a data (0) or address (1) index register. Bits 14:12 give its number. Bit 11 selects the sign-extended low half (0) or the whole register (1). Bits 10:9 give a scale of 1, 2, 4 or 8. Bits 7:0 give a signed displacement. The address is base + displacement + index*scale.
- R6: With mode 7, submode 0 gives a sign-extended one-word address and submode 1 gives a two-word address, first word high. `pc_o` equals `pc_i` plus 2 for each word consumed.
- R7: Submodes 2 and 3 of mode 7 use `pc_i` as their base, which is the counter value before the first extension word.
- R8: Submode 4 of mode 7 is an immediate (`kind_o`=3). Byte and word sizes consume one word: a byte uses its low 8 bits sign-extended and a word uses all 16 bits sign-extended. Long consumes two words, first word high, and the value appears on `imm_o`.
- R9: Submodes 5 to 7 of mode 7 set `err_o`. With `addr_only_i` set, modes 0 and 1 and the immediate also set `err_o`. An error fetches no word, writes nothing back, and reports `kind_o`=0 and `ea_o`=0.
- R10: `ea_o` carries only the low 24 bits of the computed sum.
- R11: `done_o` is a one-cycle pulse. A start while busy has no effect on the result.
- R12: A word is consumed only on a cycle with both `fetch_valid_o` and `fetch_ready_i` high. While ready is low, valid and `fetch_addr_o` (the current counter, low 24 bits) hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calculation (taken only when idle) |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register field / mode 7 submode |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| addr_only_i | input | 1 | Only an address is wanted |
| pc_i | input | 32 | Program counter at the first extension word |
| base_rd_sel_o | output | 3 | Address register number for the base read port |
| base_rd_data_i | input | 32 | Base read port data |
| idx_rd_is_addr_o | output | 1 | Index read port selects an address register |
| idx_rd_sel_o | output | 3 | Index register number |
| idx_rd_data_i | input | 32 | Index read port data |
| fetch_valid_o | output | 1 | Extension word request |
| fetch_addr_o | output | 24 | Address of the requested word |
| fetch_ready_i | input | 1 | Word available on `fetch_data_i` |
| fetch_data_i | input | 16 | Extension word |
| busy_o | output | 1 | A calculation is in progress |
| done_o | output | 1 | Result valid this cycle |
| err_o | output | 1 | Encoding rejected (with done) |
| kind_o | output | 2 | 0 memory, 1 data reg, 2 address reg, 3 immediate |
| ea_o | output | 24 | Effective address |
| imm_o | output | 32 | Immediate value |
| wb_en_o | output | 1 | Address register writeback (with done) |
| wb_reg_o | output | 3 | Writeback register number |
| wb_val_o | output | 32 | Writeback value |
| pc_o | output | 32 | Advanced program counter |

## Verification
The hardest situation to reach is a two-word fetch where the ready input stays low for several cycles. This has to happen while the start input is held high and the mode and counter inputs are changed to other values mid-operation, so that the bench can show that the captured request, the held fetch address and the counter stepping all survive the disturbance. The bench stalls the ready line at chosen points, drives a garbage mode and counter after the first cycle, and compares the fetch address on every cycle against a behavioural model that tracks how many words have been taken. Index words are built with negative displacements, both register banks, both widths and all four scales. Address bases are chosen above 24 bits so that the sums wrap and show the masking.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXT1 = 2'd1,
    ST_EXT2 = 2'd2,
    ST_FIN  = 2'd3
  } ea_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  localparam logic [1:0] KIND_MEM  = 2'd0;
  localparam logic [1:0] KIND_DREG = 2'd1;
  localparam logic [1:0] KIND_AREG = 2'd2;
  localparam logic [1:0] KIND_IMM  = 2'd3;
endpackage

// File: rtl/ea_step.sv
// Step size for postincrement / predecrement.
module ea_step #(
  parameter int          SW     = 3,
  parameter logic [2:0]  SP_REG = 3'd7
) (
  input  logic [1:0]    size_i,
  input  logic [2:0]    reg_i,
  output logic [SW-1:0] step_o
);
  always_comb begin
    case (size_i)
      2'd0:    step_o = (reg_i == SP_REG) ? SW'(2) : SW'(1);
      2'd1:    step_o = SW'(2);
      default: step_o = SW'(4);
    endcase
  end
endmodule

// File: rtl/ea_index.sv
// Brief index word: register select, width, scale and 8-bit displacement.
module ea_index #(
  parameter int DW = 32
) (
  input  logic [15:0]   ext_i,
  input  logic [DW-1:0] idx_data_i,
  output logic          idx_is_addr_o,
  output logic [2:0]    idx_sel_o,
  output logic [DW-1:0] offset_o
);
  logic [DW-1:0] idx_val;
  logic [DW-1:0] disp;

  assign idx_is_addr_o = ext_i[15];
  assign idx_sel_o     = ext_i[14:12];

  always_comb begin
    if (ext_i[11]) idx_val = idx_data_i;
    else           idx_val = {{(DW-16){idx_data_i[15]}}, idx_data_i[15:0]};
    disp     = {{(DW-8){ext_i[7]}}, ext_i[7:0]};
    offset_o = disp + (idx_val << ext_i[10:9]);
  end
endmodule

// File: rtl/ea_seq.sv
// Control sequence: capture request, fetch up to two extension words.
module ea_seq
  import ea_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    reg_i,
  input  logic [1:0]    size_i,
  input  logic          addr_only_i,
  input  logic [DW-1:0] pc_i,
  input  logic          fetch_ready_i,
  input  logic [15:0]   fetch_data_i,
  output logic          fetch_valid_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [2:0]    mode_q,
  output logic [2:0]    reg_q,
  output logic [1:0]    size_q,
  output logic          err_q,
  output logic [DW-1:0] pc_start_q,
  output logic [DW-1:0] pc_cur_q,
  output logic [15:0]   ext_hi_q,
  output logic [15:0]   ext_lo_q
);
  localparam int PC_STEP = 2;

  ea_state_t     state_q, state_d;
  logic [1:0]    nwords_q, nwords_in;
  logic          err_in, take, hs;
  logic          hi_en, lo_en, pc_en;
  logic [DW-1:0] pc_cur_d;

  // decode of the incoming request
  always_comb begin
    err_in = ((mode_i == 3'd7) && (reg_i > 3'd4)) ||
             (addr_only_i && ((mode_i < 3'd2) || ((mode_i == 3'd7) && (reg_i == 3'd4))));
    nwords_in = 2'd0;
    if (!err_in) begin
      case (mode_i)
        3'd5, 3'd6: nwords_in = 2'd1;
        3'd7: begin
          case (reg_i)
            3'd0, 3'd2, 3'd3: nwords_in = 2'd1;
            3'd1:             nwords_in = 2'd2;
            3'd4:             nwords_in = ((size_i == SZ_BYTE) || (size_i == SZ_WORD)) ? 2'd1 : 2'd2;
            default:          nwords_in = 2'd0;
          endcase
        end
        default: nwords_in = 2'd0;
      endcase
    end
  end

  assign fetch_valid_o = (state_q == ST_EXT1) || (state_q == ST_EXT2);
  assign fetch_addr_o  = pc_cur_q[AW-1:0];
  assign busy_o        = (state_q != ST_IDLE);
  assign fin_o         = (state_q == ST_FIN);
  assign hs            = fetch_valid_o && fetch_ready_i;
  assign take          = (state_q == ST_IDLE) && start_i;
  assign pc_cur_d      = pc_cur_q + DW'(PC_STEP);

  // next state
  always_comb begin
    state_d = state_q;
    hi_en   = 1'b0;
    lo_en   = 1'b0;
    pc_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) state_d = (nwords_in == 2'd0) ? ST_FIN : ST_EXT1;
      ST_EXT1: if (hs) begin
        hi_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = (nwords_q == 2'd2) ? ST_EXT2 : ST_FIN;
      end
      ST_EXT2: if (hs) begin
        lo_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      reg_q      <= '0;
      size_q     <= '0;
      err_q      <= 1'b0;
      nwords_q   <= '0;
      pc_start_q <= '0;
      pc_cur_q   <= '0;
      ext_hi_q   <= '0;
      ext_lo_q   <= '0;
    end else begin
      if (take) begin
        mode_q     <= mode_i;
        reg_q      <= reg_i;
        size_q     <= size_i;
        err_q      <= err_in;
        nwords_q   <= nwords_in;
        pc_start_q <= pc_i;
        pc_cur_q   <= pc_i;
      end else if (pc_en) begin
        pc_cur_q   <= pc_cur_d;
      end
      if (hi_en) ext_hi_q <= fetch_data_i;
      if (lo_en) ext_lo_q <= fetch_data_i;
    end
  end

  AST_FETCH_PC_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (pc_cur_q == $past(pc_cur_q) + DW'(PC_STEP))); // R6
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && !fetch_ready_i) |=> (fetch_valid_o && $stable(fetch_addr_o))); // R12
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(pc_start_q))); // R11
endmodule

// File: rtl/ea_calc_unit.sv
// Effective address calculator top.
module ea_calc_unit
  import ea_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    reg_i,
  input  logic [1:0]    size_i,
  input  logic          addr_only_i,
  input  logic [DW-1:0] pc_i,
  output logic [2:0]    base_rd_sel_o,
  input  logic [DW-1:0] base_rd_data_i,
  output logic          idx_rd_is_addr_o,
  output logic [2:0]    idx_rd_sel_o,
  input  logic [DW-1:0] idx_rd_data_i,
  output logic          fetch_valid_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ready_i,
  input  logic [15:0]   fetch_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    kind_o,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] imm_o,
  output logic          wb_en_o,
  output logic [2:0]    wb_reg_o,
  output logic [DW-1:0] wb_val_o,
  output logic [DW-1:0] pc_o
);
  localparam int SW = 3;

  logic          fin;
  logic [2:0]    mode_q, reg_q;
  logic [1:0]    size_q;
  logic          err_q;
  logic [DW-1:0] pc_start_q, pc_cur_q;
  logic [15:0]   ext_hi_q, ext_lo_q;
  logic [SW-1:0] step;
  logic [DW-1:0] offset, disp16, base, ea_full, wb_val, imm;
  logic [1:0]    kind;
  logic          wb_en;

  ea_seq #(.DW(DW), .AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .reg_i(reg_i),
    .size_i(size_i), .addr_only_i(addr_only_i), .pc_i(pc_i),
    .fetch_ready_i(fetch_ready_i), .fetch_data_i(fetch_data_i),
    .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o), .busy_o(busy_o),
    .fin_o(fin), .mode_q(mode_q), .reg_q(reg_q), .size_q(size_q), .err_q(err_q),
    .pc_start_q(pc_start_q), .pc_cur_q(pc_cur_q), .ext_hi_q(ext_hi_q), .ext_lo_q(ext_lo_q)
  );

  ea_step #(.SW(SW), .SP_REG(3'd7)) step_i (
    .size_i(size_q), .reg_i(reg_q), .step_o(step)
  );

  ea_index #(.DW(DW)) index_i (
    .ext_i(ext_hi_q), .idx_data_i(idx_rd_data_i),
    .idx_is_addr_o(idx_rd_is_addr_o), .idx_sel_o(idx_rd_sel_o), .offset_o(offset)
  );

  assign base_rd_sel_o = reg_q;
  assign base          = base_rd_data_i;
  assign disp16        = {{(DW-16){ext_hi_q[15]}}, ext_hi_q};

  always_comb begin
    ea_full = '0;
    kind    = KIND_MEM;
    imm     = '0;
    wb_en   = 1'b0;
    wb_val  = base;
    if (!err_q) begin
      case (mode_q)
        3'd0: kind = KIND_DREG;
        3'd1: kind = KIND_AREG;
        3'd2: ea_full = base;
        3'd3: begin
          ea_full = base;
          wb_en   = 1'b1;
          wb_val  = base + DW'(step);
        end
        3'd4: begin
          wb_en   = 1'b1;
          wb_val  = base - DW'(step);
          ea_full = wb_val;
        end
        3'd5: ea_full = base + disp16;
        3'd6: ea_full = base + offset;
        default: begin
          case (reg_q)
            3'd0: ea_full = disp16;
            3'd1: ea_full = DW'({ext_hi_q, ext_lo_q});
            3'd2: ea_full = pc_start_q + disp16;
            3'd3: ea_full = pc_start_q + offset;
            3'd4: begin
              kind = KIND_IMM;
              if (size_q == SZ_BYTE)      imm = {{(DW-8){ext_hi_q[7]}}, ext_hi_q[7:0]};
              else if (size_q == SZ_WORD) imm = disp16;
              else                        imm = DW'({ext_hi_q, ext_lo_q});
            end
            default: ea_full = '0;
          endcase
        end
      endcase
    end
  end

  assign done_o   = fin;
  assign err_o    = fin && err_q;
  assign kind_o   = kind;
  assign ea_o     = ea_full[AW-1:0];
  assign imm_o    = imm;
  assign wb_en_o  = fin && wb_en;
  assign wb_reg_o = reg_q;
  assign wb_val_o = wb_val;
  assign pc_o     = pc_cur_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (!wb_en_o && (kind_o == KIND_MEM) && !fetch_valid_o)); // R9
  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wb_en_o && (mode_q == 3'd4)) |-> (ea_o == wb_val_o[AW-1:0])); // R3
  AST_POSTINC_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wb_en_o && (mode_q == 3'd3)) |-> (wb_val_o[AW-1:0] != ea_o)); // R3
endmodule

// File: tb/ea_calc_unit_tb_top.sv
module ea_calc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, addr_only_i, fetch_ready_i;
  logic [2:0]  mode_i, reg_i;
  logic [1:0]  size_i;
  logic [31:0] pc_i;
  logic [15:0] fetch_data_i;
  logic [2:0]  base_rd_sel_o, idx_rd_sel_o, wb_reg_o;
  logic        idx_rd_is_addr_o, fetch_valid_o, busy_o, done_o, err_o, wb_en_o;
  logic [31:0] base_rd_data_i, idx_rd_data_i, imm_o, wb_val_o, pc_o;
  logic [23:0] fetch_addr_o, ea_o;
  logic [1:0]  kind_o;

  logic [31:0] dreg [8];
  logic [31:0] areg [8];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign base_rd_data_i = areg[base_rd_sel_o];
  assign idx_rd_data_i  = idx_rd_is_addr_o ? areg[idx_rd_sel_o] : dreg[idx_rd_sel_o];

  ea_calc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .reg_i(reg_i),
    .size_i(size_i), .addr_only_i(addr_only_i), .pc_i(pc_i),
    .base_rd_sel_o(base_rd_sel_o), .base_rd_data_i(base_rd_data_i),
    .idx_rd_is_addr_o(idx_rd_is_addr_o), .idx_rd_sel_o(idx_rd_sel_o),
    .idx_rd_data_i(idx_rd_data_i), .fetch_valid_o(fetch_valid_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ready_i(fetch_ready_i),
    .fetch_data_i(fetch_data_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .kind_o(kind_o), .ea_o(ea_o), .imm_o(imm_o), .wb_en_o(wb_en_o),
    .wb_reg_o(wb_reg_o), .wb_val_o(wb_val_o), .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural model results
  int          e_words;
  bit          e_err, e_wb;
  logic [1:0]  e_kind;
  logic [31:0] e_ea, e_imm, e_wbval;

  function automatic logic [31:0] sx16(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  function automatic logic [31:0] idx_off(input logic [15:0] x);
    logic [31:0] v;
    v = x[15] ? areg[x[14:12]] : dreg[x[14:12]];
    if (!x[11]) v = sx16(v[15:0]);
    return {{24{x[7]}}, x[7:0]} + v * (32'd1 << x[10:9]);
  endfunction

  task automatic model(input int m, input int r, input int sz, input bit ao,
                       input logic [31:0] pc, input logic [15:0] w0, input logic [15:0] w1);
    int st;
    logic [31:0] a;
    a = areg[r];
    st = (sz == 0) ? ((r == 7) ? 2 : 1) : ((sz == 1) ? 2 : 4);
    e_words = 0; e_err = 0; e_wb = 0; e_kind = 0; e_ea = 0; e_imm = 0; e_wbval = a;
    if (m == 7 && r >= 5) e_err = 1;
    else if (ao && (m == 0 || m == 1 || (m == 7 && r == 4))) e_err = 1;
    else if (m == 0) e_kind = 1;
    else if (m == 1) e_kind = 2;
    else if (m == 2) e_ea = a;
    else if (m == 3) begin e_ea = a; e_wb = 1; e_wbval = a + st; end
    else if (m == 4) begin e_wbval = a - st; e_ea = e_wbval; e_wb = 1; end
    else if (m == 5) begin e_words = 1; e_ea = a + sx16(w0); end
    else if (m == 6) begin e_words = 1; e_ea = a + idx_off(w0); end
    else if (r == 0) begin e_words = 1; e_ea = sx16(w0); end
    else if (r == 1) begin e_words = 2; e_ea = {w0, w1}; end
    else if (r == 2) begin e_words = 1; e_ea = pc + sx16(w0); end
    else if (r == 3) begin e_words = 1; e_ea = pc + idx_off(w0); end
    else begin
      e_kind = 3;
      if (sz == 0)      begin e_words = 1; e_imm = {{24{w0[7]}}, w0[7:0]}; end
      else if (sz == 1) begin e_words = 1; e_imm = sx16(w0); end
      else              begin e_words = 2; e_imm = {w0, w1}; end
    end
  endtask

  task automatic run_op(input string req, input int m, input int r, input int sz,
                        input bit ao, input logic [31:0] pc,
                        input logic [15:0] w0, input logic [15:0] w1,
                        input int stall, input bit hold);
    int cyc = 0;
    int wi = 0;
    int sl = stall;
    bit got = 0;
    model(m, r, sz, ao, pc, w0, w1);
    start_i = 1; mode_i = 3'(m); reg_i = 3'(r); size_i = 2'(sz); addr_only_i = ao; pc_i = pc;
    while (!got && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (hold) begin mode_i = 3'd7; reg_i = 3'd6; pc_i = 32'hDEAD0000; end
      else start_i = 0;
      if (done_o) got = 1;
      else if (fetch_valid_o) begin
        // R12: fetch address tracks the counter each cycle
        if (fetch_addr_o !== 24'(pc + 2 * wi)) chk({req, " R12 fetch addr"}, 32'(fetch_addr_o), 32'(24'(pc + 2 * wi)));
        if (sl > 0) begin fetch_ready_i = 0; sl--; end
        else begin fetch_ready_i = 1; fetch_data_i = (wi == 0) ? w0 : w1; wi++; end
      end else fetch_ready_i = 0;
    end
    start_i = 0; fetch_ready_i = 0;
    chk({req, " R11 done cycle"}, 32'(cyc), 32'(1 + e_words + ((e_words > 0) ? stall : 0)));
    chk({req, " R12 words taken"}, 32'(wi), 32'(e_words));
    chk({req, " R9 err"}, 32'(err_o), 32'(e_err));
    chk({req, " kind"}, 32'(kind_o), 32'(e_kind));
    chk({req, " R10 ea"}, 32'(ea_o), 32'(e_ea[23:0]));
    chk({req, " R6 pc"}, pc_o, pc + 32'(2 * e_words));
    chk({req, " wb_en"}, 32'(wb_en_o), 32'(e_wb));
    if (e_wb) begin
      chk({req, " R3 wb reg"}, 32'(wb_reg_o), 32'(r));
      chk({req, " R3 wb val"}, wb_val_o, e_wbval);
    end
    if (e_kind == 3) chk({req, " R8 imm"}, imm_o, e_imm);
    @(negedge clk);
    chk({req, " R11 pulse"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; mode_i = 0; reg_i = 0; size_i = 0; addr_only_i = 0;
    pc_i = 0; fetch_ready_i = 0; fetch_data_i = 0;
    for (int i = 0; i < 8; i++) begin
      dreg[i] = 32'h0001_0000 * (i + 1) + 32'h10 * i;
      areg[i] = 32'hFF10_0000 + 32'h100 * i;
    end
    dreg[2] = 32'h1234_FFFE;   // low half negative
    areg[5] = 32'h0000_0030;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 fetch", 32'(fetch_valid_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", 32'(busy_o), 0);

    run_op("R2 dreg",        0, 3, 2, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R2 areg",        1, 6, 1, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 indirect",    2, 4, 1, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 postinc b7",  3, 7, 0, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 postinc l",   3, 2, 2, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 predec b",    4, 3, 0, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 predec b7",   4, 7, 0, 0, 32'h1000, 0, 0, 0, 0);
    run_op("R3 predec w",    4, 1, 1, 1, 32'h1000, 0, 0, 0, 0);
    run_op("R4 disp neg",    5, 5, 1, 0, 32'h2000, 16'hFFF0, 0, 0, 0);
    run_op("R4 disp pos",    5, 1, 1, 0, 32'h2000, 16'h7FFF, 0, 1, 0);
    run_op("R5 idx A long x8", 6, 0, 2, 0, 32'h3000, 16'b1_101_1_11_0_1000_0000, 0, 0, 0);
    run_op("R5 idx D word x2", 6, 5, 1, 0, 32'h3000, 16'b0_010_0_01_0_0000_0101, 0, 2, 0);
    run_op("R5 idx D long x1", 6, 5, 1, 0, 32'h3000, 16'b0_010_1_00_0_1111_1111, 0, 0, 0);
    run_op("R6 abs short",   7, 0, 1, 0, 32'h00FF_FFFE, 16'h8004, 0, 0, 0);
    run_op("R6 abs long",    7, 1, 2, 1, 32'h4000, 16'h12AB, 16'hCDEF, 3, 0);
    run_op("R7 pc disp",     7, 2, 1, 0, 32'h5000, 16'hFFFE, 0, 0, 0);
    run_op("R7 R5 pc idx",   7, 3, 1, 0, 32'h5000, 16'b1_011_0_10_0_1111_1100, 0, 1, 0);
    run_op("R8 imm byte",    7, 4, 0, 0, 32'h6000, 16'h7F85, 0, 0, 0);
    run_op("R8 imm word",    7, 4, 1, 0, 32'h6000, 16'h8001, 0, 0, 0);
    run_op("R8 imm long",    7, 4, 2, 0, 32'h6000, 16'hA5A5, 16'h5A5A, 2, 0);
    run_op("R9 submode5",    7, 5, 1, 0, 32'h7000, 0, 0, 0, 0);
    run_op("R9 submode7",    7, 7, 2, 0, 32'h7000, 0, 0, 0, 0);
    run_op("R9 ao dreg",     0, 1, 1, 1, 32'h7000, 0, 0, 0, 0);
    run_op("R9 ao areg",     1, 1, 1, 1, 32'h7000, 0, 0, 0, 0);
    run_op("R9 ao imm",      7, 4, 2, 1, 32'h7000, 0, 0, 0, 0);
    run_op("R10 wrap",       5, 0, 1, 0, 32'h7000, 16'h7000, 0, 0, 0);
    // R11: start held high with changed inputs while busy, with stalls
    run_op("R11 busy start", 7, 1, 2, 0, 32'h8000, 16'h0012, 16'h3456, 4, 1);
    run_op("R11 busy idx",   6, 2, 0, 0, 32'h8000, 16'b1_111_1_01_0_0000_0001, 0, 2, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule